// File: doc/BRIEF.md
# NIC Control Register File

This block is the software-visible control space of a simple packet network interface. A host issues single-beat requests carrying a 12-bit offset, a width flag (4 or 8 bytes), a direction and 64 bits of data. The block checks every request against a fixed table of legal offsets, widths and directions. A request that fails the check gets an error response and changes nothing. A request that passes reads or updates the configuration, interrupt and descriptor registers.

The two completion words, one per direction, are not stored whole. At read time they are assembled from a small stored part (busy, complete, copy length) and from live signals sent by the FIFOs: packet counts, transmit fill level and the watermark compares against fixed limits. Writing a descriptor hands it to the receive or transmit engine through a one-cycle load strobe. The interrupt status gathers event pulses from the engines. Software clears it by reading it, or clears chosen bits by writing ones to them. A command write resets all of the state to its parameter-defined values.

Top module: `nic_csr_block`

## Requirements
- R1: Only the offsets in this map are legal. 4-byte: 0x000 config (rw), 0x004 command (write-only), 0x008 interrupt status (rw), 0x00C interrupt mask (rw), 0x010 rx max copy, 0x014 tx max copy, 0x018 rx max interrupts, 0x020 rx fifo size, 0x024 tx fifo size, 0x028 rx high mark, 0x02C tx low mark. 8-byte: 0x030 rx descriptor (rw), 0x038 rx done, 0x040 rx wait, 0x048 tx descriptor (rw), 0x050 tx done, 0x058 tx wait, 0x060 station address. Registers not marked rw or write-only are read-only. Any other offset is an error: 0x01C, the upper halves of 8-byte registers, unaligned offsets, and anything at or above 0x068.
- R2: A request whose width flag (`req_wide`=1 for 8 bytes) does not match the register's width is an error and changes no state.
- R3: A read of the command register, or a write of a read-only register, is an error and changes no state.
- R4: Every request gets a response exactly one cycle later. An error response carries zero data. A write response carries zero data. A 4-byte read returns its value zero-extended in bits 31:0.
- R5: After `rst`, or after a legal write of the command register with bit 0 set, the following values hold: config is 0x100 when DEDICATED is set and 0 otherwise; interrupt mask is 0x8A; interrupt status, both descriptors and both stored completion parts are zero. The fixed registers always read their parameter values. A command reset pulses `dev_reset` for one cycle, and it overrides every other update in the same cycle.
- R6: A done word reads as follows: bits 47:32 hold the matching FIFO packet count, sampled in the request cycle; bit 31 is busy; bit 30 is complete; bits 19:0 hold the copy length; bits 63:48 are zero. A wait register always returns the same value as its done register.
- R7: Tx done bit 29 is set when (tx fifo size − `tx_fill_bytes`) < tx max copy, with the free space taken as 0 when the fill is not below the size. Tx done bit 28 is set when `tx_fill_bytes` < tx low mark.
- R8: A legal write of a descriptor while its engine is idle stores the data, sets the stored done part to 0x8000_0000 (busy only), and raises the load strobe for one cycle together with the response. The same write while the engine is not idle is an error and changes nothing.
- R9: A completion pulse stores complete (bit 30) and the supplied info (rx bits 29:0, tx length in bits 19:0), with busy cleared. A descriptor write in the same cycle takes precedence.
- R10: Interrupt bits are rx packet (0), rx copy done (1), rx empty (2), rx above high mark (3), tx packet (4), tx copy done (5), tx full (6) and tx below low mark (7). Event pulses on `intr_post` set status bits. A legal read of the status returns the value held before that cycle's events and then clears it. An event arriving in the same cycle as the read stays set.
- R11: A legal write of the status clears exactly the bits written as 1. Events in the same cycle stay set.
- R12: `intr_pending` is high exactly when some status bit is set whose mask bit is also set.
- R13: Config reads back all 32 bits written to it. The interrupt mask reads back the low 8 bits written to it. `cfg_out` shows the config register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | 12 | Byte offset in the register space |
| req_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Read data |
| rx_pkt_count | input | 16 | Packets held in the receive FIFO |
| tx_pkt_count | input | 16 | Packets held in the transmit FIFO |
| tx_fill_bytes | input | 32 | Bytes held in the transmit FIFO |
| rx_idle | input | 1 | Receive engine can accept a descriptor |
| tx_idle | input | 1 | Transmit engine can accept a descriptor |
| rx_cpl_valid | input | 1 | Receive copy finished |
| rx_cpl_word | input | 30 | Receive completion info (flags and length) |
| tx_cpl_valid | input | 1 | Transmit copy finished |
| tx_cpl_len | input | 20 | Transmit copy length |
| intr_post | input | 8 | Interrupt event pulses |
| cfg_out | output | 32 | Current config register |
| rx_desc_load | output | 1 | New receive descriptor strobe |
| rx_desc | output | 64 | Receive descriptor |
| tx_desc_load | output | 1 | New transmit descriptor strobe |
| tx_desc | output | 64 | Transmit descriptor |
| intr_pending | output | 1 | Unmasked interrupt pending |
| dev_reset | output | 1 | One-cycle pulse after a command reset |

## Verification
Interrupt status is the one register with two writers in a cycle: software clears it by reading, or by writing ones, while the engines post events on `intr_post`. The bench posts events in the same cycle as a status read and as a write-one-to-clear. It expects the returned value to exclude the new events and the register to keep them. It also lands a descriptor write on the same cycle as a completion pulse for that engine, and a command reset on the same cycle as pending events. In each case the next read and `intr_pending` are compared against the reference model.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 64;
    localparam int INTR_W = 8;
    localparam int PKT_W  = 16;
    localparam int LEN_W  = 20;

    // completion word bit positions
    localparam int DN_BUSY   = 31;
    localparam int DN_CMPL   = 30;
    localparam int DN_FULL   = 29;
    localparam int DN_LOW    = 28;
    localparam int DN_PKT_LO = 32;

    // interrupt bits
    localparam int IB_RX_PKT   = 0;
    localparam int IB_RX_DMA   = 1;
    localparam int IB_RX_EMPTY = 2;
    localparam int IB_RX_HIGH  = 3;
    localparam int IB_TX_PKT   = 4;
    localparam int IB_TX_DMA   = 5;
    localparam int IB_TX_FULL  = 6;
    localparam int IB_TX_LOW   = 7;

    localparam logic [INTR_W-1:0] MASK_AT_RESET =
        INTR_W'((1 << IB_RX_HIGH) | (1 << IB_RX_DMA) | (1 << IB_TX_LOW));

    localparam int CFG_DEDICATED_BIT = 8;
    localparam int CMD_RESET_BIT     = 0;

    typedef enum logic [4:0] {
        RG_NONE, RG_CFG, RG_CMD, RG_ISTAT, RG_IMASK,
        RG_RX_MAXCOPY, RG_TX_MAXCOPY, RG_RX_MAXINTR,
        RG_RX_FIFOSZ, RG_TX_FIFOSZ, RG_RX_MARK, RG_TX_MARK,
        RG_RX_DESC, RG_RX_DONE, RG_RX_WAIT,
        RG_TX_DESC, RG_TX_DONE, RG_TX_WAIT, RG_STATION
    } reg_id_e;

    typedef struct packed {
        logic    hit;
        logic    wide;
        logic    rd_ok;
        logic    wr_ok;
        reg_id_e id;
    } reg_attr_t;

    function automatic reg_attr_t mk_attr(reg_id_e id, logic wide, logic rd, logic wr);
        reg_attr_t r;
        r.hit   = 1'b1;
        r.wide  = wide;
        r.rd_ok = rd;
        r.wr_ok = wr;
        r.id    = id;
        return r;
    endfunction

    function automatic reg_attr_t reg_lookup(logic [ADDR_W-1:0] a);
        reg_attr_t r;
        r = '{hit: 1'b0, wide: 1'b0, rd_ok: 1'b0, wr_ok: 1'b0, id: RG_NONE};
        case (a)
            12'h000: r = mk_attr(RG_CFG,        1'b0, 1'b1, 1'b1);
            12'h004: r = mk_attr(RG_CMD,        1'b0, 1'b0, 1'b1);
            12'h008: r = mk_attr(RG_ISTAT,      1'b0, 1'b1, 1'b1);
            12'h00C: r = mk_attr(RG_IMASK,      1'b0, 1'b1, 1'b1);
            12'h010: r = mk_attr(RG_RX_MAXCOPY, 1'b0, 1'b1, 1'b0);
            12'h014: r = mk_attr(RG_TX_MAXCOPY, 1'b0, 1'b1, 1'b0);
            12'h018: r = mk_attr(RG_RX_MAXINTR, 1'b0, 1'b1, 1'b0);
            12'h020: r = mk_attr(RG_RX_FIFOSZ,  1'b0, 1'b1, 1'b0);
            12'h024: r = mk_attr(RG_TX_FIFOSZ,  1'b0, 1'b1, 1'b0);
            12'h028: r = mk_attr(RG_RX_MARK,    1'b0, 1'b1, 1'b0);
            12'h02C: r = mk_attr(RG_TX_MARK,    1'b0, 1'b1, 1'b0);
            12'h030: r = mk_attr(RG_RX_DESC,    1'b1, 1'b1, 1'b1);
            12'h038: r = mk_attr(RG_RX_DONE,    1'b1, 1'b1, 1'b0);
            12'h040: r = mk_attr(RG_RX_WAIT,    1'b1, 1'b1, 1'b0);
            12'h048: r = mk_attr(RG_TX_DESC,    1'b1, 1'b1, 1'b1);
            12'h050: r = mk_attr(RG_TX_DONE,    1'b1, 1'b1, 1'b0);
            12'h058: r = mk_attr(RG_TX_WAIT,    1'b1, 1'b1, 1'b0);
            12'h060: r = mk_attr(RG_STATION,    1'b1, 1'b1, 1'b0);
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nic_csr_decode.sv
module nic_csr_decode
    import nic_csr_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              acc_err,
    output reg_id_e           acc_id
);
    reg_attr_t attr;

    always_comb begin
        attr    = reg_lookup(req_addr);
        acc_id  = attr.id;
        acc_err = req_valid &&
                  (!attr.hit ||
                   (attr.wide != req_wide) ||
                   (req_write ? !attr.wr_ok : !attr.rd_ok));
    end
endmodule

// File: rtl/nic_csr_done.sv
module nic_csr_done
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              wipe,
    input  logic              load,
    input  logic              cpl_valid,
    input  logic [29:0]       cpl_info,
    input  logic [PKT_W-1:0]  pkt_count,
    input  logic [1:0]        live_flags,
    output logic [DATA_W-1:0] word
);
    logic [31:0] low_q;

    always_ff @(posedge clk) begin
        if (wipe)
            low_q <= '0;
        else if (load)
            low_q <= 32'(1) << DN_BUSY;
        else if (cpl_valid)
            low_q <= {1'b0, 1'b1, cpl_info};
    end

    always_comb begin
        word = '0;
        word[DN_PKT_LO +: PKT_W] = pkt_count;
        word[31:0]               = low_q;
        word[DN_FULL]            = low_q[DN_FULL] | live_flags[1];
        word[DN_LOW]             = low_q[DN_LOW]  | live_flags[0];
    end
endmodule

// File: rtl/nic_csr_intr.sv
module nic_csr_intr
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              wipe,
    input  logic [INTR_W-1:0] post,
    input  logic              rd_clr,
    input  logic              w1c_en,
    input  logic [INTR_W-1:0] w1c_bits,
    input  logic              mask_we,
    input  logic [INTR_W-1:0] mask_wdata,
    output logic [INTR_W-1:0] status,
    output logic [INTR_W-1:0] mask,
    output logic              pending
);
    logic [INTR_W-1:0] clr;

    always_comb begin
        clr = '0;
        if (rd_clr) clr = '1;
        else if (w1c_en) clr = w1c_bits;
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            status <= '0;
            mask   <= MASK_AT_RESET;
        end else begin
            status <= (status & ~clr) | post;
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign pending = |(status & mask);
endmodule

// File: rtl/nic_csr_block.sv
module nic_csr_block
    import nic_csr_pkg::*;
#(
    parameter int unsigned RX_MAX_COPY   = 1514,
    parameter int unsigned TX_MAX_COPY   = 16384,
    parameter int unsigned RX_MAX_INTR   = 10,
    parameter int unsigned RX_FIFO_BYTES = 65536,
    parameter int unsigned TX_FIFO_BYTES = 65536,
    parameter int unsigned RX_HIGH_MARK  = 49152,
    parameter int unsigned TX_LOW_MARK   = 16384,
    parameter logic [47:0] STATION_ADDR  = 48'h0090_0000_0001,
    parameter bit          DEDICATED     = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_wide,
    input  logic [11:0] req_addr,
    input  logic [63:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [63:0] rsp_rdata,
    input  logic [15:0] rx_pkt_count,
    input  logic [15:0] tx_pkt_count,
    input  logic [31:0] tx_fill_bytes,
    input  logic        rx_idle,
    input  logic        tx_idle,
    input  logic        rx_cpl_valid,
    input  logic [29:0] rx_cpl_word,
    input  logic        tx_cpl_valid,
    input  logic [19:0] tx_cpl_len,
    input  logic [7:0]  intr_post,
    output logic [31:0] cfg_out,
    output logic        rx_desc_load,
    output logic [63:0] rx_desc,
    output logic        tx_desc_load,
    output logic [63:0] tx_desc,
    output logic        intr_pending,
    output logic        dev_reset
);
    localparam logic [31:0] CFG_AT_RESET = DEDICATED ? (32'(1) << CFG_DEDICATED_BIT) : 32'(0);

    logic        dec_err, busy_err, err;
    reg_id_e     acc_id;
    logic        acc_rd, acc_wr, cmd_rst, wipe;
    logic        rx_load_now, tx_load_now;
    logic [31:0] cfg_q;
    logic [63:0] rx_desc_q, tx_desc_q;
    logic [63:0] rx_word, tx_word, rd_mux;
    logic [7:0]  stat_w, mask_w;
    logic [31:0] tx_free;
    logic        tx_full_now, tx_low_now;

    nic_csr_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .acc_err   (dec_err),
        .acc_id    (acc_id)
    );

    // descriptor writes are refused while the engine is working
    assign busy_err = req_valid && req_write &&
                      ((acc_id == RG_RX_DESC && !rx_idle) ||
                       (acc_id == RG_TX_DESC && !tx_idle));
    assign err      = dec_err || busy_err;
    assign acc_rd   = req_valid && !err && !req_write;
    assign acc_wr   = req_valid && !err &&  req_write;
    assign cmd_rst  = acc_wr && (acc_id == RG_CMD) && req_wdata[CMD_RESET_BIT];
    assign wipe     = rst || cmd_rst;

    assign rx_load_now = acc_wr && (acc_id == RG_RX_DESC);
    assign tx_load_now = acc_wr && (acc_id == RG_TX_DESC);

    // live transmit FIFO compares
    assign tx_free     = (tx_fill_bytes >= TX_FIFO_BYTES) ? 32'(0) : (TX_FIFO_BYTES - tx_fill_bytes);
    assign tx_full_now = tx_free < TX_MAX_COPY;
    assign tx_low_now  = tx_fill_bytes < TX_LOW_MARK;

    nic_csr_done u_rx_done (
        .clk        (clk),
        .wipe       (wipe),
        .load       (rx_load_now),
        .cpl_valid  (rx_cpl_valid),
        .cpl_info   (rx_cpl_word),
        .pkt_count  (rx_pkt_count),
        .live_flags (2'b00),
        .word       (rx_word)
    );

    nic_csr_done u_tx_done (
        .clk        (clk),
        .wipe       (wipe),
        .load       (tx_load_now),
        .cpl_valid  (tx_cpl_valid),
        .cpl_info   ({10'b0, tx_cpl_len}),
        .pkt_count  (tx_pkt_count),
        .live_flags ({tx_full_now, tx_low_now}),
        .word       (tx_word)
    );

    nic_csr_intr u_intr (
        .clk        (clk),
        .wipe       (wipe),
        .post       (intr_post),
        .rd_clr     (acc_rd && acc_id == RG_ISTAT),
        .w1c_en     (acc_wr && acc_id == RG_ISTAT),
        .w1c_bits   (req_wdata[7:0]),
        .mask_we    (acc_wr && acc_id == RG_IMASK),
        .mask_wdata (req_wdata[7:0]),
        .status     (stat_w),
        .mask       (mask_w),
        .pending    (intr_pending)
    );

    always_comb begin
        case (acc_id)
            RG_CFG:        rd_mux = 64'(cfg_q);
            RG_ISTAT:      rd_mux = 64'(stat_w);
            RG_IMASK:      rd_mux = 64'(mask_w);
            RG_RX_MAXCOPY: rd_mux = 64'(RX_MAX_COPY);
            RG_TX_MAXCOPY: rd_mux = 64'(TX_MAX_COPY);
            RG_RX_MAXINTR: rd_mux = 64'(RX_MAX_INTR);
            RG_RX_FIFOSZ:  rd_mux = 64'(RX_FIFO_BYTES);
            RG_TX_FIFOSZ:  rd_mux = 64'(TX_FIFO_BYTES);
            RG_RX_MARK:    rd_mux = 64'(RX_HIGH_MARK);
            RG_TX_MARK:    rd_mux = 64'(TX_LOW_MARK);
            RG_RX_DESC:    rd_mux = rx_desc_q;
            RG_RX_DONE,
            RG_RX_WAIT:    rd_mux = rx_word;
            RG_TX_DESC:    rd_mux = tx_desc_q;
            RG_TX_DONE,
            RG_TX_WAIT:    rd_mux = tx_word;
            RG_STATION:    rd_mux = 64'(STATION_ADDR);
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            cfg_q     <= CFG_AT_RESET;
            rx_desc_q <= '0;
            tx_desc_q <= '0;
        end else if (acc_wr) begin
            if (acc_id == RG_CFG)     cfg_q     <= req_wdata[31:0];
            if (acc_id == RG_RX_DESC) rx_desc_q <= req_wdata;
            if (acc_id == RG_TX_DESC) tx_desc_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_rdata    <= '0;
            rx_desc_load <= 1'b0;
            tx_desc_load <= 1'b0;
            dev_reset    <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_err      <= req_valid && err;
            rsp_rdata    <= acc_rd ? rd_mux : '0;
            rx_desc_load <= rx_load_now;
            tx_desc_load <= tx_load_now;
            dev_reset    <= cmd_rst;
        end
    end

    assign cfg_out = cfg_q;
    assign rx_desc = rx_desc_q;
    assign tx_desc = tx_desc_q;
endmodule

// File: rtl/nic_csr_checker.sv
module nic_csr_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_wide,
    input logic [11:0] req_addr,
    input logic [63:0] req_wdata,
    input logic [7:0]  intr_post,
    input logic        rx_idle,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [63:0] rsp_rdata,
    input logic        rx_desc_load,
    input logic [31:0] cfg_out,
    input logic        dev_reset,
    input logic [7:0]  istat,
    input logic [7:0]  imask
);
    assert_out_of_range_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr >= 12'h068) |=> rsp_err);

    assert_bad_width_keeps_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_wide && req_addr == 12'h000) |=> (rsp_err && $stable(cfg_out)));

    assert_cmd_not_readable_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 12'h004) |=> rsp_err);

    assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_err_data_zero_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 64'h0));

    assert_cmd_reset_values_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_wide && req_addr == 12'h004 && req_wdata[0])
        |=> (dev_reset && imask == 8'h8A && istat == 8'h00));

    assert_load_needs_idle_R8: assert property (@(posedge clk) disable iff (rst)
        rx_desc_load |-> (rsp_valid && !rsp_err && $past(rx_idle)));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_wide && req_addr == 12'h008 && intr_post == 8'h00)
        |=> istat == 8'h00);

    assert_w1c_bits_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_wide && req_addr == 12'h008 && intr_post == 8'h00)
        |=> istat == ($past(istat) & ~$past(req_wdata[7:0])));
endmodule

bind nic_csr_block nic_csr_checker u_nic_csr_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_wide     (req_wide),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .intr_post    (intr_post),
    .rx_idle      (rx_idle),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .rx_desc_load (rx_desc_load),
    .cfg_out      (cfg_out),
    .dev_reset    (dev_reset),
    .istat        (stat_w),
    .imask        (mask_w)
);

// File: tb/nic_csr_block_bench.sv
module nic_csr_block_bench;
    localparam int unsigned RXMAX  = 1514;
    localparam int unsigned TXMAX  = 16384;
    localparam int unsigned RXINTR = 10;
    localparam int unsigned RXF    = 65536;
    localparam int unsigned TXF    = 65536;
    localparam int unsigned RXMARK = 49152;
    localparam int unsigned TXMARK = 16384;
    localparam logic [47:0] MAC    = 48'h0a1b_2c3d_4e5f;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [15:0] rx_pkt_count = '0, tx_pkt_count = '0;
    logic [31:0] tx_fill_bytes = '0;
    logic        rx_idle = 1'b1, tx_idle = 1'b1;
    logic        rx_cpl_valid = 1'b0, tx_cpl_valid = 1'b0;
    logic [29:0] rx_cpl_word = '0;
    logic [19:0] tx_cpl_len = '0;
    logic [7:0]  intr_post = '0;
    logic [31:0] cfg_out;
    logic        rx_desc_load, tx_desc_load, intr_pending, dev_reset;
    logic [63:0] rx_desc, tx_desc;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_cfg = 32'h100, m_rxdone = '0, m_txdone = '0;
    logic [7:0]  m_stat = '0, m_mask = 8'h8A;
    logic [63:0] m_rxd = '0, m_txd = '0;
    logic        e_valid = 0, e_err = 0, e_rxl = 0, e_txl = 0, e_dr = 0;
    logic [63:0] e_rdata = '0;

    always #5 clk = ~clk;

    nic_csr_block #(
        .RX_MAX_COPY(RXMAX), .TX_MAX_COPY(TXMAX), .RX_MAX_INTR(RXINTR),
        .RX_FIFO_BYTES(RXF), .TX_FIFO_BYTES(TXF), .RX_HIGH_MARK(RXMARK),
        .TX_LOW_MARK(TXMARK), .STATION_ADDR(MAC), .DEDICATED(1'b1)
    ) u_nic_csr_block (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .rx_pkt_count(rx_pkt_count), .tx_pkt_count(tx_pkt_count),
        .tx_fill_bytes(tx_fill_bytes), .rx_idle(rx_idle), .tx_idle(tx_idle),
        .rx_cpl_valid(rx_cpl_valid), .rx_cpl_word(rx_cpl_word),
        .tx_cpl_valid(tx_cpl_valid), .tx_cpl_len(tx_cpl_len),
        .intr_post(intr_post), .cfg_out(cfg_out),
        .rx_desc_load(rx_desc_load), .rx_desc(rx_desc),
        .tx_desc_load(tx_desc_load), .tx_desc(tx_desc),
        .intr_pending(intr_pending), .dev_reset(dev_reset)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // one clock: drive, predict, advance, compare
    task automatic step(input bit v, input bit w, input bit wide,
                        input logic [11:0] a, input logic [63:0] d);
        bit known, ew, rok, wok, err, do_rst;
        logic [63:0] val, rxw, txw;
        logic [32:0] free;
        logic [7:0]  clr;
        logic [31:0] n_cfg, n_rxdone, n_txdone;
        logic [7:0]  n_stat, n_mask;
        logic [63:0] n_rxd, n_txd;
        bit n_rxl, n_txl;
        req_valid = v; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
        n_cfg = m_cfg; n_rxdone = m_rxdone; n_txdone = m_txdone;
        n_mask = m_mask; n_rxd = m_rxd; n_txd = m_txd;
        n_rxl = 0; n_txl = 0; do_rst = 0; clr = '0;
        rxw = {16'h0, rx_pkt_count, m_rxdone};
        free = ({1'b0, tx_fill_bytes} >= 33'(TXF)) ? 33'd0 : 33'(TXF) - {1'b0, tx_fill_bytes};
        txw = {16'h0, tx_pkt_count, m_txdone};
        txw[29] = free < 33'(TXMAX);
        txw[28] = tx_fill_bytes < TXMARK;
        known = 1; ew = 0; rok = 1; wok = 0; val = '0;
        case (a)
            12'h000: begin wok = 1; val = 64'(m_cfg); end
            12'h004: begin rok = 0; wok = 1; end
            12'h008: begin wok = 1; val = 64'(m_stat); end
            12'h00C: begin wok = 1; val = 64'(m_mask); end
            12'h010: val = 64'(RXMAX);
            12'h014: val = 64'(TXMAX);
            12'h018: val = 64'(RXINTR);
            12'h020: val = 64'(RXF);
            12'h024: val = 64'(TXF);
            12'h028: val = 64'(RXMARK);
            12'h02C: val = 64'(TXMARK);
            12'h030: begin ew = 1; wok = 1; val = m_rxd; end
            12'h038, 12'h040: begin ew = 1; val = rxw; end
            12'h048: begin ew = 1; wok = 1; val = m_txd; end
            12'h050, 12'h058: begin ew = 1; val = txw; end
            12'h060: begin ew = 1; val = 64'(MAC); end
            default: known = 0;
        endcase
        err = v && (!known || ew != wide || (w ? !wok : !rok));
        if (v && !err && w && a == 12'h030 && !rx_idle) err = 1;
        if (v && !err && w && a == 12'h048 && !tx_idle) err = 1;
        if (rx_cpl_valid) n_rxdone = {2'b01, rx_cpl_word};
        if (tx_cpl_valid) n_txdone = {2'b01, 10'b0, tx_cpl_len};
        if (v && !err) begin
            if (!w && a == 12'h008) clr = 8'hFF;
            if (w) begin
                case (a)
                    12'h000: n_cfg = d[31:0];
                    12'h004: do_rst = d[0];
                    12'h008: clr = d[7:0];
                    12'h00C: n_mask = d[7:0];
                    12'h030: begin n_rxd = d; n_rxdone = 32'h8000_0000; n_rxl = 1; end
                    12'h048: begin n_txd = d; n_txdone = 32'h8000_0000; n_txl = 1; end
                    default: ;
                endcase
            end
        end
        n_stat = (m_stat & ~clr) | intr_post;
        if (rst || do_rst) begin
            n_cfg = 32'h100; n_mask = 8'h8A; n_stat = '0;
            n_rxd = '0; n_txd = '0; n_rxdone = '0; n_txdone = '0;
        end
        @(posedge clk);
        @(negedge clk);
        m_cfg = n_cfg; m_mask = n_mask; m_stat = n_stat;
        m_rxd = n_rxd; m_txd = n_txd; m_rxdone = n_rxdone; m_txdone = n_txdone;
        e_valid = v && !rst;
        e_err   = err && !rst;
        e_rdata = (!rst && v && !err && !w) ? val : 64'h0;
        e_rxl   = n_rxl && !rst;
        e_txl   = n_txl && !rst;
        e_dr    = do_rst && !rst;
        chk("R4 rsp_valid", 64'(rsp_valid), 64'(e_valid));
        chk("R1 R2 R3 R8 rsp_err", 64'(rsp_err), 64'(e_err));
        chk("R4 R5 R6 R7 R9 R10 R13 rsp_rdata", rsp_rdata, e_rdata);
        chk("R8 rx_desc_load", 64'(rx_desc_load), 64'(e_rxl));
        chk("R8 tx_desc_load", 64'(tx_desc_load), 64'(e_txl));
        chk("R8 rx_desc", rx_desc, m_rxd);
        chk("R8 tx_desc", tx_desc, m_txd);
        chk("R13 cfg_out", 64'(cfg_out), 64'(m_cfg));
        chk("R12 intr_pending", 64'(intr_pending), 64'(|(m_stat & m_mask)));
        chk("R5 dev_reset", 64'(dev_reset), 64'(e_dr));
        req_valid = 0;
        intr_post = '0; rx_cpl_valid = 0; tx_cpl_valid = 0;
    endtask

    task automatic rd(input logic [11:0] a, input bit wide);
        step(1, 0, wide, a, 64'h0);
    endtask

    task automatic wr(input logic [11:0] a, input bit wide, input logic [63:0] d);
        step(1, 1, wide, a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(0, 0, 0, 12'h0, 64'h0);
        step(0, 0, 0, 12'h0, 64'h0);
        rst = 1'b0;
        step(0, 0, 0, 12'h0, 64'h0);

        // R5: reset values and fixed registers
        rd(12'h000, 0); rd(12'h00C, 0); rd(12'h008, 0);
        rd(12'h010, 0); rd(12'h014, 0); rd(12'h018, 0); rd(12'h020, 0);
        rd(12'h024, 0); rd(12'h028, 0); rd(12'h02C, 0); rd(12'h060, 1);

        // R13: config and mask read back
        wr(12'h000, 0, 64'hFFFF_FFFF_DEAD_BEEF); rd(12'h000, 0);
        wr(12'h00C, 0, 64'h0000_0000_0000_01F3); rd(12'h00C, 0);

        // R1: illegal offsets
        rd(12'h01C, 0); rd(12'h034, 1); rd(12'h068, 1); rd(12'h100, 0);
        rd(12'h002, 0); wr(12'h03C, 1, 64'h1);

        // R2: width mismatch changes nothing
        wr(12'h000, 1, 64'h1234); wr(12'h030, 0, 64'h55); rd(12'h038, 0);
        rd(12'h000, 0); rd(12'h030, 1);

        // R3: direction errors
        rd(12'h004, 0); wr(12'h010, 0, 64'h7); wr(12'h038, 1, 64'h9);
        wr(12'h060, 1, 64'h9); rd(12'h010, 0);

        // R8 R6: rx descriptor then done/wait words
        rx_pkt_count = 16'd5;
        wr(12'h030, 1, 64'h0000_05EA_0012_3400);
        rd(12'h038, 1); rd(12'h040, 1);
        // R8: busy engine refuses
        rx_idle = 0;
        wr(12'h030, 1, 64'hAAAA_BBBB_CCCC_DDDD); rd(12'h030, 1);
        // R9: completion
        rx_cpl_valid = 1; rx_cpl_word = 30'h2030_05EA;
        step(0, 0, 0, 12'h0, 64'h0);
        rx_pkt_count = 16'hFFFF;
        rd(12'h038, 1); rd(12'h040, 1);
        // R9: descriptor write and completion in the same cycle
        rx_idle = 1;
        rx_cpl_valid = 1; rx_cpl_word = 30'h0000_0040;
        wr(12'h030, 1, 64'h0000_0100_0000_8000); rd(12'h038, 1);

        // R7: tx watermark and free space boundaries
        tx_pkt_count = 16'd3;
        wr(12'h048, 1, 64'h0000_4000_0000_9000); rd(12'h050, 1);
        tx_cpl_valid = 1; tx_cpl_len = 20'h04000;
        step(0, 0, 0, 12'h0, 64'h0);
        tx_fill_bytes = 32'd16383; rd(12'h050, 1);
        tx_fill_bytes = 32'd16384; rd(12'h058, 1);
        tx_fill_bytes = 32'd49152; rd(12'h050, 1);
        tx_fill_bytes = 32'd49153; rd(12'h050, 1);
        tx_fill_bytes = 32'd70000; rd(12'h050, 1);
        tx_idle = 0; wr(12'h048, 1, 64'h1); tx_idle = 1;

        // R10 R12: events, read-to-clear, collision with a post
        wr(12'h00C, 0, 64'h8A);
        intr_post = 8'h01; step(0, 0, 0, 12'h0, 64'h0);
        intr_post = 8'h02; step(0, 0, 0, 12'h0, 64'h0);
        intr_post = 8'h80; rd(12'h008, 0);
        rd(12'h008, 0); rd(12'h008, 0);
        // R11: write-one-to-clear with a same-cycle post
        intr_post = 8'hF0; step(0, 0, 0, 12'h0, 64'h0);
        wr(12'h008, 0, 64'h30); rd(12'h008, 0);
        intr_post = 8'h0C; step(0, 0, 0, 12'h0, 64'h0);
        intr_post = 8'h02; wr(12'h008, 0, 64'h0E); rd(12'h008, 0);
        wr(12'h00C, 0, 64'h00); intr_post = 8'h01; step(0, 0, 0, 12'h0, 64'h0);
        wr(12'h00C, 0, 64'h01);

        // R5: command reset with pending events in the same cycle
        wr(12'h000, 0, 64'h0F); intr_post = 8'hFF;
        wr(12'h004, 0, 64'h0000_0000_0000_0001);
        rd(12'h000, 0); rd(12'h00C, 0); rd(12'h008, 0);
        rd(12'h030, 1); rd(12'h038, 1); rd(12'h050, 1);
        // command without bit 0 has no effect
        wr(12'h000, 0, 64'h3); wr(12'h004, 0, 64'h2); rd(12'h000, 0);
        step(0, 0, 0, 12'h0, 64'h0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule